// File: doc/BRIEF.md
# Interrupt Request Capture with Per-Line Trigger Select

This block turns eight raw interrupt request lines into a registered pending-request vector. Each line first passes through a two-flop synchronizer. A per-line trigger-mode register then picks one of two behaviours. In level mode the pending bit simply follows the synchronized line. In edge mode a rising transition latches the pending bit, and it stays set until acknowledge logic clears it. The block keeps a remembered copy of each line's previous synchronized level in both modes, so a change of mode never creates a spurious edge.

Software writes the trigger-mode register as a whole byte. A fixed per-instance writable-bit mask, given as a parameter, forces some lines to stay edge triggered whatever value is written. Next to the pending vector, the block gives a one-cycle flag per line when a request is newly accepted. A masked line still updates its pending bit but never raises that flag. Priority resolution and the bus interface sit outside this block.

Top module: `irq_capture`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level) has its pending bit equal to the synchronized line level: high sets it, low clears it.
- R2: A line whose trigger-mode bit is 0 (edge) sets its pending bit only when the synchronized level is high and the remembered previous level is low.
- R3: In edge mode, the line returning low does not clear the pending bit.
- R4: The remembered level is updated every cycle in both modes. A line held high while it is switched from level to edge mode does not raise a new request.
- R5: A trigger-mode write stores the write data ANDed with the parameter WRITE_MASK (default 8'hF8). Bits that are 0 in the mask always read back 0.
- R6: A line whose mask input bit is 1 still updates its pending bit, but its new-request flag stays 0.
- R7: An acknowledge strobe clears the pending bit of an edge-mode line on the next edge, unless a new rising edge is accepted in that same cycle.
- R8: An acknowledge strobe has no effect on a level-mode line, which stays pending while its synchronized level is high.
- R9: While reset is asserted and after it, the pending bits, remembered levels, synchronizer, new-request flags and trigger-mode register are all 0.
- R10: A change on a request input held across a clock edge appears in the pending vector two edges later, after the two synchronizer stages.
- R11: The new-request flag for a line is 1 for one cycle, in the same cycle its pending bit first becomes 1, and only if that bit was 0 before and the line is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqIn | input | 8 | Raw asynchronous request lines |
| maskIn | input | 8 | Per-line mask; 1 suppresses the new-request flag |
| ackClr | input | 8 | Per-line acknowledge clear strobes |
| trigWrEn | input | 1 | Trigger-mode register write enable |
| trigWrData | input | 8 | Trigger-mode write data; 1 = level, 0 = edge |
| trigMode | output | 8 | Current trigger-mode register |
| pending | output | 8 | Pending-request vector |
| newReq | output | 8 | One-cycle flag per newly accepted request |

## Verification
Single lines are pulsed and held in edge mode. This separates latching on a rise from tracking, and shows that a falling line leaves the bit set until an acknowledge arrives. The same lines are then driven in level mode with acknowledges present, which shows that pending follows the line and ignores clears. A line is held high across a switch from level to edge mode to check that the remembered level stops a false edge. Masked lines and writes of all ones, including to non-writable bits, show how masking and the writable-bit filter differ. A long random phase then mixes writes, masks, acknowledges and toggles, and the bench compares against its model on every cycle.

// File: rtl/irq_capture_pkg.sv
package irq_capture_pkg;
  localparam int IRQ_LINES = 8;

  typedef struct packed {
    logic [IRQ_LINES-1:0] setLine;
    logic [IRQ_LINES-1:0] clrLine;
  } capStrobes_t;
endpackage

// File: rtl/irq_capture_control.sv
module irq_capture_control
  import irq_capture_pkg::*;
#(
  parameter logic [IRQ_LINES-1:0] WRITE_MASK = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trigWrEn,
  input  logic [IRQ_LINES-1:0] trigWrData,
  input  logic [IRQ_LINES-1:0] syncLvl,
  input  logic [IRQ_LINES-1:0] lastLvl,
  input  logic [IRQ_LINES-1:0] ackClr,
  output logic [IRQ_LINES-1:0] trigMode,
  output capStrobes_t          strobes
);
  always_ff @(posedge clk) begin
    if (!rst_n) trigMode <= '0;
    else if (trigWrEn) trigMode <= trigWrData & WRITE_MASK;
  end

  for (genvar i = 0; i < IRQ_LINES; i++) begin : g_line
    always_comb begin
      if (trigMode[i]) begin
        strobes.setLine[i] = syncLvl[i];
        strobes.clrLine[i] = ~syncLvl[i];
      end else begin
        strobes.setLine[i] = syncLvl[i] & ~lastLvl[i];
        strobes.clrLine[i] = ackClr[i];
      end
    end
  end

  // R5: stored value is filtered by the writable-bit mask
  a_r5_write_filter: assert property (@(posedge clk) disable iff (!rst_n)
    trigWrEn |=> trigMode == ($past(trigWrData) & WRITE_MASK));
endmodule

// File: rtl/irq_capture_datapath.sv
module irq_capture_datapath
  import irq_capture_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IRQ_LINES-1:0] reqIn,
  input  logic [IRQ_LINES-1:0] maskIn,
  input  capStrobes_t          strobes,
  output logic [IRQ_LINES-1:0] syncLvl,
  output logic [IRQ_LINES-1:0] lastLvl,
  output logic [IRQ_LINES-1:0] pending,
  output logic [IRQ_LINES-1:0] newReq
);
  logic [IRQ_LINES-1:0] syncStage [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) syncStage[s] <= '0;
      else if (s == 0) syncStage[s] <= reqIn;
      else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
    end
  end

  assign syncLvl = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastLvl <= '0;
      pending <= '0;
      newReq  <= '0;
    end else begin
      lastLvl <= syncLvl;
      pending <= (pending & ~strobes.clrLine) | strobes.setLine;
      newReq  <= strobes.setLine & ~pending & ~maskIn;
    end
  end

  // R6: a masked line never reports a new request
  a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (newReq & $past(maskIn)) == '0);
  // R11: flag only accompanies a freshly set pending bit
  a_r11_flag_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (newReq & (~pending | $past(pending))) == '0);
  // R4: remembered level trails the synchronized level by one cycle
  a_r4_last_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    lastLvl == $past(syncLvl));
endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import irq_capture_pkg::*;
#(
  parameter logic [IRQ_LINES-1:0] WRITE_MASK  = 8'hF8,
  parameter int                   SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IRQ_LINES-1:0] reqIn,
  input  logic [IRQ_LINES-1:0] maskIn,
  input  logic [IRQ_LINES-1:0] ackClr,
  input  logic                 trigWrEn,
  input  logic [IRQ_LINES-1:0] trigWrData,
  output logic [IRQ_LINES-1:0] trigMode,
  output logic [IRQ_LINES-1:0] pending,
  output logic [IRQ_LINES-1:0] newReq
);
  capStrobes_t          strobes;
  logic [IRQ_LINES-1:0] syncLvl;
  logic [IRQ_LINES-1:0] lastLvl;

  irq_capture_control #(.WRITE_MASK(WRITE_MASK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trigWrEn(trigWrEn), .trigWrData(trigWrData),
    .syncLvl(syncLvl), .lastLvl(lastLvl), .ackClr(ackClr),
    .trigMode(trigMode), .strobes(strobes)
  );

  irq_capture_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .reqIn(reqIn), .maskIn(maskIn),
    .strobes(strobes), .syncLvl(syncLvl), .lastLvl(lastLvl),
    .pending(pending), .newReq(newReq)
  );

  // R1: level-mode lines mirror the synchronized level
  a_r1_level_track: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & $past(trigMode)) == ($past(syncLvl) & $past(trigMode)));
  // R3: edge-mode pending bits only drop on an acknowledge
  a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pending) & ~$past(trigMode) & ~$past(ackClr) & ~pending) == '0);
  // R8: acknowledge cannot clear a high level-mode line
  a_r8_level_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trigMode) & $past(syncLvl) & $past(ackClr) & ~pending) == '0);
  // R5: non-writable bits never hold a 1
  a_r5_fixed_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (trigMode & ~WRITE_MASK) == '0);
endmodule

// File: tb/irq_capture_tb.sv
module irq_capture_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reqIn = '0, maskIn = '0, ackClr = '0, trigWrData = '0;
  logic       trigWrEn = 1'b0;
  logic [7:0] trigMode, pending, newReq;

  irq_capture u_dut (
    .clk(clk), .rst_n(rst_n), .reqIn(reqIn), .maskIn(maskIn), .ackClr(ackClr),
    .trigWrEn(trigWrEn), .trigWrData(trigWrData),
    .trigMode(trigMode), .pending(pending), .newReq(newReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    compared = 0, mismatched = 0;
  bit    done = 1'b0;
  string tag = "R9";

  // behavioural model
  logic [7:0] lvlQ[$];
  logic [7:0] mTrig, mPend, mNew, mLast;

  task automatic modelReset();
    lvlQ = {8'h00, 8'h00};
    mTrig = '0; mPend = '0; mNew = '0; mLast = '0;
  endtask

  task automatic modelStep();
    logic [7:0] s;
    s = lvlQ.pop_front();
    lvlQ.push_back(reqIn);
    for (int i = 0; i < 8; i++) begin
      bit acc;
      acc = mTrig[i] ? s[i] : (s[i] && !mLast[i]);
      mNew[i] = acc && !mPend[i] && !maskIn[i];
      if (mTrig[i]) mPend[i] = s[i];
      else mPend[i] = acc || (mPend[i] && !ackClr[i]);
    end
    mLast = s;
    if (trigWrEn) mTrig = trigWrData & 8'hF8;
  endtask

  task automatic compare();
    compared++;
    if (pending !== mPend || newReq !== mNew || trigMode !== mTrig) begin
      mismatched++;
      $display("FAIL %s t=%0t pending=%h/%h newReq=%h/%h trigMode=%h/%h (actual/expected)",
               tag, $time, pending, mPend, newReq, mNew, trigMode, mTrig);
    end
  endtask

  // drive at negedge, advance model after posedge, compare
  task automatic cyc(input logic [7:0] rq, input logic [7:0] mk,
                     input logic [7:0] ak, input bit we = 0, input logic [7:0] wd = 0);
    @(negedge clk);
    reqIn = rq; maskIn = mk; ackClr = ak; trigWrEn = we; trigWrData = wd;
    @(posedge clk); #1;
    if (!rst_n) modelReset(); else modelStep();
    compare();
  endtask

  task automatic idle(input logic [7:0] rq, input int n);
    for (int k = 0; k < n; k++) cyc(rq, 8'h00, 8'h00);
  endtask

  initial begin
    modelReset();
    tag = "R9";
    cyc(8'hFF, 8'h00, 8'h00, 1, 8'hFF);
    cyc(8'hFF, 8'h00, 8'hFF);
    @(negedge clk); rst_n = 1'b1; reqIn = '0; trigWrEn = 0; ackClr = '0;
    @(posedge clk); #1; modelStep(); compare();
    idle(8'h00, 3);

    tag = "R5"; cyc(8'h00, 0, 0, 1, 8'hFF); cyc(8'h00, 0, 0, 1, 8'h07); idle(8'h00, 1);

    tag = "R2"; cyc(8'h01, 0, 0); idle(8'h01, 3);
    tag = "R10"; idle(8'h01, 1);
    tag = "R3"; idle(8'h00, 4);
    tag = "R11"; idle(8'h01, 3); idle(8'h00, 2);
    tag = "R7"; cyc(8'h00, 0, 8'h01); idle(8'h00, 3);

    tag = "R1"; cyc(8'h00, 0, 0, 1, 8'hF8); idle(8'h30, 4); idle(8'h10, 4);
    tag = "R8"; cyc(8'h10, 0, 8'hFF); cyc(8'h10, 0, 8'hFF); idle(8'h10, 2);
    tag = "R6"; cyc(8'hC0, 8'h40, 0); cyc(8'hC0, 8'h40, 0); idle(8'hC0, 3);
    tag = "R4"; cyc(8'hC0, 0, 0, 1, 8'h00); idle(8'hC0, 2);
    cyc(8'hC0, 0, 8'hC0); idle(8'hC0, 4);

    tag = "R7";
    for (int k = 0; k < 400; k++) begin
      logic [7:0] r;
      r = 8'($urandom);
      cyc(8'($urandom), r & 8'($urandom), 8'($urandom) & 8'($urandom),
          ($urandom % 16) == 0, 8'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule